// File: doc/BRIEF.md
# Fast Ethernet Transmit 4B/5B Symbol Encoder

This block sits between a nibble-wide transmit source and a serial line coder. It runs on a single clock at the bit rate, five times the nibble rate. An internal five-phase counter divides that clock and raises a one-cycle nibble strobe. The source holds transmit enable and the data nibble steady across the clock edge where the strobe is high, and the block samples them there. Each sample produces one 5-bit code group. That code group is presented in parallel for five cycles and shifted out most significant bit first.

Framing follows transmit enable. While no frame is active, the idle code goes out. When enable is first seen high, the first two slots carry the start delimiter pair (J then K) in place of the first two preamble nibbles, so a frame keeps the same length in symbols. Every later slot with enable high carries the mapped data nibble. The first slot with enable low after the data carries T, and the following slot carries R. Idle then resumes. The pairs are never cut short: K always follows J, and R always follows T, whatever enable does in those slots.

Top module: `fe_sym_encoder`

## Requirements
- R1: While reset is held, sym_out is 11111, ser_bit is 1 and nib_strobe is 0. After reset is released, nib_strobe is first high in the cycle after the fourth rising clock edge.
- R2: nib_strobe is high for exactly one cycle out of every five. tx_en and txd are sampled at the rising edge that ends that cycle.
- R3: When no frame is active, a slot sampled with tx_en low emits the idle code 11111, whatever txd holds.
- R4: The first slot sampled with tx_en high while idle emits J = 11000. The next slot emits K = 10001. The txd values sampled in these two slots are discarded.
- R5: Later slots sampled with tx_en high emit the 4B/5B code of txd: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: The first slot after the K slot that is sampled with tx_en low emits T = 01101. The next slot emits R = 00111. Idle follows.
- R7: If tx_en is high for a single slot only, the block still emits the full sequence J, K, T, R.
- R8: After each sampling edge, ser_bit carries the new code group over the next five cycles, most significant bit first.
- R9: sym_out changes only at sampling edges and is held for the five cycles of its slot.
- R10: tx_en sampled in the R slot is ignored. If tx_en is high at the next slot, that slot emits J and starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, five cycles per nibble |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable, sampled when nib_strobe is high |
| txd | input | 4 | Transmit data nibble, sampled with tx_en |
| nib_strobe | output | 1 | High in the cycle whose closing edge samples the inputs |
| sym_out | output | 5 | Code group of the current slot |
| ser_bit | output | 1 | Serialized code group, most significant bit first |

## Verification
On every cycle the assertions check the following. The strobe never lasts two cycles. The parallel symbol moves only at sampling edges. The first serial bit after an edge matches the new symbol's top bit. Every emitted code group has at least two ones. The framing states follow each other legally: idle to the second start slot, last data to the end slot, end slot back to idle. Only the bench scenarios can show the rest: the exact code of each of the sixteen nibbles, the discarded preamble nibbles, the J K T R order for frames of every length from one to eighteen, the bit order of each symbol, and a new frame starting right after R.

// File: rtl/fe_enc_pkg.sv
package fe_enc_pkg;

  localparam logic [4:0] SYM_IDLE = 5'b11111;
  localparam logic [4:0] SYM_J    = 5'b11000;
  localparam logic [4:0] SYM_K    = 5'b10001;
  localparam logic [4:0] SYM_T    = 5'b01101;
  localparam logic [4:0] SYM_R    = 5'b00111;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SSD2 = 2'd1,
    FS_DATA = 2'd2,
    FS_ESD2 = 2'd3
  } fs_t;

  // 4B/5B data code lookup
  function automatic logic [4:0] nib_to_code(input logic [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fe_nibble_mapper.sv
module fe_nibble_mapper
  import fe_enc_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int SYM_W = 5
) (
  input  logic [NIB_W-1:0] nib,
  output logic [SYM_W-1:0] code
);
  always_comb begin
    code = nib_to_code(nib);
  end
endmodule

// File: rtl/fe_frame_ctrl.sv
module fe_frame_ctrl
  import fe_enc_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tx_en,
  input  logic [SYM_W-1:0] data_code,
  output logic [SYM_W-1:0] next_sym
);
  fs_t st, st_n;

  always_comb begin
    st_n     = st;
    next_sym = SYM_IDLE;
    case (st)
      FS_IDLE: begin
        next_sym = tx_en ? SYM_J : SYM_IDLE;
        st_n     = tx_en ? FS_SSD2 : FS_IDLE;
      end
      FS_SSD2: begin
        next_sym = SYM_K;
        st_n     = FS_DATA;
      end
      FS_DATA: begin
        next_sym = tx_en ? data_code : SYM_T;
        st_n     = tx_en ? FS_DATA : FS_ESD2;
      end
      default: begin
        next_sym = SYM_R;
        st_n     = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= FS_IDLE;
    else if (load) st <= st_n;
  end

  // R4
  start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && st == FS_IDLE && tx_en) |=> st == FS_SSD2);
  // R6
  end_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && st == FS_DATA && !tx_en) |=> st == FS_ESD2);
  // R10
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && st == FS_ESD2) |=> st == FS_IDLE);
endmodule

// File: rtl/fe_sym_serializer.sv
module fe_sym_serializer #(
  parameter int         SYM_W    = 5,
  parameter logic [4:0] IDLE_SYM = 5'b11111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] next_sym,
  output logic             load,
  output logic [SYM_W-1:0] sym_q,
  output logic             ser_bit
);
  localparam int PH_W = $clog2(SYM_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);

  logic [PH_W-1:0]  ph;
  logic [SYM_W-1:0] shreg;

  assign load    = (ph == PH_LAST);
  assign ser_bit = shreg[SYM_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= '0;
      sym_q <= SYM_W'(IDLE_SYM);
      shreg <= SYM_W'(IDLE_SYM);
    end else if (load) begin
      ph    <= '0;
      sym_q <= next_sym;
      shreg <= next_sym;
    end else begin
      ph    <= ph + 1'b1;
      shreg <= {shreg[SYM_W-2:0], 1'b0};
    end
  end

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  // R9
  sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sym_q));
  // R8
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ser_bit == sym_q[SYM_W-1]);
endmodule

// File: rtl/fe_sym_encoder.sv
module fe_sym_encoder
  import fe_enc_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  output logic             nib_strobe,
  output logic [SYM_W-1:0] sym_out,
  output logic             ser_bit
);
  logic [SYM_W-1:0] data_code;
  logic [SYM_W-1:0] next_sym;
  logic             load;

  fe_nibble_mapper #(.NIB_W(NIB_W), .SYM_W(SYM_W)) u_map (
    .nib  (txd),
    .code (data_code)
  );

  fe_frame_ctrl #(.SYM_W(SYM_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .tx_en     (tx_en),
    .data_code (data_code),
    .next_sym  (next_sym)
  );

  fe_sym_serializer #(.SYM_W(SYM_W), .IDLE_SYM(SYM_IDLE)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .next_sym (next_sym),
    .load     (load),
    .sym_q    (sym_out),
    .ser_bit  (ser_bit)
  );

  assign nib_strobe = load;

  // R5
  code_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sym_out) >= 2);
endmodule

// File: tb/tb_fe_sym_encoder.sv
module tb_fe_sym_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       nib_strobe;
  logic [4:0] sym_out;
  logic       ser_bit;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [4:0] C_I = 5'b11111;
  localparam logic [4:0] C_J = 5'b11000;
  localparam logic [4:0] C_K = 5'b10001;
  localparam logic [4:0] C_T = 5'b01101;
  localparam logic [4:0] C_R = 5'b00111;
  // data codes, nibble F down to nibble 0
  localparam logic [79:0] CODES = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};

  always #4 clk = ~clk;

  fe_sym_encoder dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd),
    .nib_strobe(nib_strobe), .sym_out(sym_out), .ser_bit(ser_bit));

  function automatic logic [4:0] code_of(input logic [3:0] n);
    return CODES[int'(n)*5 +: 5];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic slot(input logic en, input logic [3:0] d, input logic [4:0] exp, input string req);
    while (!nib_strobe) @(negedge clk);
    tx_en = en;
    txd   = d;
    @(negedge clk);
    chk(sym_out == exp, req, sym_out, exp);
    for (int k = 0; k < 5; k++) begin
      if (k > 0) @(negedge clk);
      chk(ser_bit == exp[4-k], "R8", {4'b0, ser_bit}, {4'b0, exp[4-k]});
      chk(nib_strobe == (k == 4), "R2", {4'b0, nib_strobe}, {4'b0, 1'(k == 4)});
    end
    chk(sym_out == exp, "R9", sym_out, exp);
  endtask

  task automatic frame(input int len, input logic [3:0] base, input logic r_en);
    int L;
    L = (len < 2) ? 2 : len;
    for (int i = 0; i < L; i++) begin
      logic [3:0] d;
      logic [4:0] e;
      string r;
      d = base + 4'(i);
      if (i == 0) begin e = C_J; r = (len == 1) ? "R7" : "R4"; end
      else if (i == 1) begin e = C_K; r = (len == 1) ? "R7" : "R4"; end
      else begin e = code_of(d); r = "R5"; end
      slot(i < len, d, e, r);
    end
    slot(1'b0, ~base, C_T, (len == 1) ? "R7" : "R6");
    slot(r_en, 4'h5, C_R, r_en ? "R10" : "R6");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sym_out == C_I, "R1", sym_out, C_I);
    chk(ser_bit == 1'b1, "R1", {4'b0, ser_bit}, 5'd1);
    chk(nib_strobe == 1'b0, "R1", {4'b0, nib_strobe}, 5'd0);
    rst_n = 1'b1;
    n = 0;
    while (!nib_strobe && n < 20) begin @(negedge clk); n++; end
    chk(n == 4, "R1", 5'(n), 5'd4);
    chk(sym_out == C_I, "R1", sym_out, C_I);
    // R3 idle sweep over all data values
    for (int d = 0; d < 16; d++) slot(1'b0, 4'(d), C_I, "R3");
    // frames of lengths 1..18
    for (int len = 1; len <= 18; len++) begin
      frame(len, 4'(len * 3), 1'b0);
      slot(1'b0, 4'hA, C_I, "R3");
      slot(1'b0, 4'h0, C_I, "R3");
    end
    // R10 enable high during R slot, then new frame right away
    frame(5, 4'h0, 1'b1);
    frame(4, 4'h7, 1'b1);
    frame(18, 4'hF, 1'b0);
    slot(1'b0, 4'hF, C_I, "R3");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule